// File: doc/BRIEF.md
# Permissioned Register Front End for a Serial Target

This block is the byte-level register side of a two-wire serial target. A separate bus engine handles the bit timing and passes it one decoded event per cycle: a start (with the transfer direction), a received write byte, a request for a read byte, or a stop. For every start, write byte and read request the block answers one cycle later with an acknowledge flag and, for reads, a data byte.

An internal 8-bit pointer selects the register. It is loaded from the first data byte of each write transfer and advances after every accepted access. Each address has a permission class: read-only, read/write, select-only or invalid. Violations are reported in an error register with separate codes, so software can tell a transfer that started on a bad address from one that ran off the end of the valid range. Selecting one special address and then ending the transfer makes the block re-sample three strap pins into the low bits of its own bus address.

The eight read/write registers drive configuration outputs for a port (direction, output latch, rising and falling change enables, pull-up, input threshold, open-drain and slew control). Two live inputs can be read: the pin levels and the change flags. A read of the change flags also sends a clear pulse.

Top module: `regfront_top`

## Requirements
- R1: Each start, write-byte or read-request event produces exactly one response cycle (rsp_valid high) on the next clock; a stop event produces none. A start in the write direction is always acknowledged.
- R2: The first write byte after a write-direction start is always acknowledged and loads the pointer; it writes no register.
- R3: A later write byte aimed at a read/write address (0x03-0x06, 0x08-0x0B) is acknowledged, stored, and the pointer advances by one. Address 0x03 drives dir_o, 0x04 lat_o, 0x05 rise_en_o, 0x06 fall_en_o, 0x08 pullup_o, 0x09 thresh_o, 0x0A opendrain_o, 0x0B slew_o.
- R4: A write byte aimed at any other address is not acknowledged, changes no register and leaves the pointer unchanged; every further write byte of that transfer is also not acknowledged. The error code is 0x04 if it was the first data byte after the pointer byte, otherwise 0x02.
- R5: A read-direction start while the pointer holds an unreadable address (anything but 0x00-0x06 and 0x08-0x0B) is not acknowledged, sets error 0x03, and every read byte of that transfer returns 0x00.
- R6: A read byte at a readable address returns that register and advances the pointer: 0x00 returns the error code, 0x01 returns ioc_flags_i with ioc_clr_o high in the response cycle, 0x02 returns pin_state_i, the others return the stored values.
- R7: When a read reaches an unreadable address, that byte and all later bytes of the transfer return 0x00, the pointer stays where it is, and error 0x01 is set.
- R8: A read of address 0x00 returns the held error code and clears it to 0x00; a new error replaces any code already held.
- R9: One clock after reset, and at a stop that directly follows a pointer byte of 0xB0, dev_addr_o becomes 0x60 with addr_pins_i in bits 2:0; at other stops it is unchanged. A data byte aimed at 0xB0 is refused like any other non-writable address.
- R10: After reset the error code and pointer are 0x00 and the outputs hold dir 0xFF, lat 0x00, rise 0x00, fall 0x00, pullup 0xFF, thresh 0x00, opendrain 0x00, slew 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start or repeated start with matched address |
| start_rd | input | 1 | Direction of the start: 1 read, 0 write |
| ev_wr | input | 1 | A write byte has been received |
| wr_data | input | 8 | The received write byte |
| ev_rd | input | 1 | The engine needs the next read byte |
| ev_stop | input | 1 | Stop condition |
| addr_pins_i | input | 3 | Strap pins for the low address bits |
| pin_state_i | input | 8 | Current pin levels |
| ioc_flags_i | input | 8 | Pending change flags |
| rsp_valid | output | 1 | Response cycle |
| rsp_ack | output | 1 | Acknowledge (1) or refuse (0) |
| rsp_data | output | 8 | Read data byte |
| ioc_clr_o | output | 1 | Change flags were read; clear them |
| dev_addr_o | output | 7 | Current 7-bit bus address |
| dir_o | output | 8 | Direction register |
| lat_o | output | 8 | Output latch register |
| rise_en_o | output | 8 | Rising-edge enable register |
| fall_en_o | output | 8 | Falling-edge enable register |
| pullup_o | output | 8 | Pull-up enable register |
| thresh_o | output | 8 | Input threshold register |
| opendrain_o | output | 8 | Open-drain enable register |
| slew_o | output | 8 | Slew control register |

## Verification
The assertions take for granted that the bus engine raises at most one event in any cycle, issues read requests only inside a read-direction transfer and write bytes only inside a write-direction one; one of them checks the single-event rule directly. The stimulus drives every event for exactly one cycle with an idle cycle after it, always opens a transfer with a start, and changes the strap pins only between transfers, so response timing and address sampling stay within those assumptions.

// File: rtl/regfront_pkg.sv
package regfront_pkg;

    localparam int DATA_W  = 8;
    localparam int PTR_W   = 8;
    localparam int NUM_CFG = 8;

    typedef enum logic [1:0] {
        PERM_IV = 2'd0,
        PERM_RO = 2'd1,
        PERM_RW = 2'd2,
        PERM_SO = 2'd3
    } perm_e;

    localparam logic [DATA_W-1:0] ERR_RD_OVR = 8'h01;
    localparam logic [DATA_W-1:0] ERR_WR_OVR = 8'h02;
    localparam logic [DATA_W-1:0] ERR_RD_BAD = 8'h03;
    localparam logic [DATA_W-1:0] ERR_WR_BAD = 8'h04;

    localparam logic [PTR_W-1:0] ADR_ERR  = 8'h00;
    localparam logic [PTR_W-1:0] ADR_IOC  = 8'h01;
    localparam logic [PTR_W-1:0] ADR_PIN  = 8'h02;
    localparam logic [PTR_W-1:0] ADR_LO_A = 8'h03;
    localparam logic [PTR_W-1:0] ADR_LO_B = 8'h06;
    localparam logic [PTR_W-1:0] ADR_HI_A = 8'h08;
    localparam logic [PTR_W-1:0] ADR_HI_B = 8'h0B;
    localparam logic [PTR_W-1:0] ADR_SEL  = 8'hB0;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] err;
        logic              want_ptr;
        logic              began;
        logic              wr_fault;
        logic              rd_fault;
        logic              so_sel;
        logic              rsp_valid;
        logic              rsp_ack;
        logic [DATA_W-1:0] rsp_data;
        logic              ioc_clr;
    } ctrl_s;

    function automatic logic [DATA_W-1:0] cfg_reset(input int idx);
        case (idx)
            0, 4, 7: cfg_reset = 8'hFF;
            default: cfg_reset = 8'h00;
        endcase
    endfunction

    function automatic logic [2:0] cfg_index(input logic [PTR_W-1:0] a);
        logic [PTR_W-1:0] t;
        t = (a < ADR_HI_A) ? (a - ADR_LO_A) : (a - 8'd4);
        cfg_index = t[2:0];
    endfunction

endpackage

// File: rtl/regfront_perm.sv
module regfront_perm
    import regfront_pkg::*;
(
    input  logic [PTR_W-1:0] addr,
    output perm_e            perm
);
    always_comb begin
        if (addr <= ADR_PIN)
            perm = PERM_RO;
        else if (addr >= ADR_LO_A && addr <= ADR_LO_B)
            perm = PERM_RW;
        else if (addr >= ADR_HI_A && addr <= ADR_HI_B)
            perm = PERM_RW;
        else if (addr == ADR_SEL)
            perm = PERM_SO;
        else
            perm = PERM_IV;
    end
endmodule

// File: rtl/regfront_regs.sv
module regfront_regs
    import regfront_pkg::*;
#(
    parameter int NUM   = NUM_CFG,
    parameter int DW    = DATA_W,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DW-1:0]          wr_val,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DW-1:0]          rd_val,
    output logic [NUM-1:0][DW-1:0] cfg_q
);
    logic [NUM-1:0][DW-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en)
            cfg_d[wr_idx] = wr_val;
    end

    for (genvar i = 0; i < NUM; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[i] <= DW'(cfg_reset(i));
            else
                cfg_q[i] <= cfg_d[i];
        end
    end

    assign rd_val = cfg_q[rd_idx];

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/regfront_addr.sv
module regfront_addr #(
    parameter int             PIN_W  = 3,
    parameter int             AW     = 7,
    parameter logic [AW-1:0]  BASE   = 7'h60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resample,
    input  logic [PIN_W-1:0] pins,
    output logic [AW-1:0]    dev_addr
);
    logic          boot_d, boot_q;
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        boot_d = 1'b0;
        addr_d = addr_q;
        if (boot_q || resample)
            addr_d = {BASE[AW-1:PIN_W], pins};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_q <= 1'b1;
            addr_q <= BASE;
        end else begin
            boot_q <= boot_d;
            addr_q <= addr_d;
        end
    end

    assign dev_addr = addr_q;

    // R9
    addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!resample && !boot_q) |=> $stable(dev_addr));
endmodule

// File: rtl/regfront_top.sv
module regfront_top
    import regfront_pkg::*;
#(
    parameter int              PIN_W     = 3,
    parameter int              DEV_AW    = 7,
    parameter logic [DEV_AW-1:0] BASE_ADDR = 7'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              start_rd,
    input  logic              ev_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_rd,
    input  logic              ev_stop,
    input  logic [PIN_W-1:0]  addr_pins_i,
    input  logic [DATA_W-1:0] pin_state_i,
    input  logic [DATA_W-1:0] ioc_flags_i,
    output logic              rsp_valid,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ioc_clr_o,
    output logic [DEV_AW-1:0] dev_addr_o,
    output logic [DATA_W-1:0] dir_o,
    output logic [DATA_W-1:0] lat_o,
    output logic [DATA_W-1:0] rise_en_o,
    output logic [DATA_W-1:0] fall_en_o,
    output logic [DATA_W-1:0] pullup_o,
    output logic [DATA_W-1:0] thresh_o,
    output logic [DATA_W-1:0] opendrain_o,
    output logic [DATA_W-1:0] slew_o
);
    ctrl_s                          q, d;
    perm_e                          perm_ptr, perm_new;
    logic                           rd_ok, wr_ok;
    logic                           cfg_we, resample;
    logic [DATA_W-1:0]              cfg_rd, rd_mux;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg;
    logic [PTR_W-1:0]               ptr_q;

    assign ptr_q = q.ptr;

    regfront_perm u_perm_ptr (.addr(q.ptr),   .perm(perm_ptr));
    regfront_perm u_perm_new (.addr(wr_data), .perm(perm_new));

    assign rd_ok = (perm_ptr == PERM_RO) || (perm_ptr == PERM_RW);
    assign wr_ok = (perm_ptr == PERM_RW);

    regfront_regs #(.NUM(NUM_CFG), .DW(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_index(q.ptr)),
        .wr_val (wr_data),
        .rd_idx (cfg_index(q.ptr)),
        .rd_val (cfg_rd),
        .cfg_q  (cfg)
    );

    regfront_addr #(.PIN_W(PIN_W), .AW(DEV_AW), .BASE(BASE_ADDR)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .resample (resample),
        .pins     (addr_pins_i),
        .dev_addr (dev_addr_o)
    );

    always_comb begin
        case (q.ptr)
            ADR_ERR: rd_mux = q.err;
            ADR_IOC: rd_mux = ioc_flags_i;
            ADR_PIN: rd_mux = pin_state_i;
            default: rd_mux = cfg_rd;
        endcase
    end

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_ack   = 1'b0;
        d.rsp_data  = '0;
        d.ioc_clr   = 1'b0;
        cfg_we      = 1'b0;
        resample    = 1'b0;

        if (ev_start) begin
            d.rsp_valid = 1'b1;
            d.want_ptr  = !start_rd;
            d.began     = 1'b1;
            d.wr_fault  = 1'b0;
            d.rd_fault  = 1'b0;
            d.so_sel    = 1'b0;
            if (start_rd && !rd_ok) begin
                d.rsp_ack  = 1'b0;
                d.rd_fault = 1'b1;
                d.err      = ERR_RD_BAD;
            end else begin
                d.rsp_ack  = 1'b1;
            end
        end else if (ev_wr) begin
            d.rsp_valid = 1'b1;
            d.so_sel    = 1'b0;
            if (q.want_ptr) begin
                d.ptr      = wr_data;
                d.want_ptr = 1'b0;
                d.rsp_ack  = 1'b1;
                d.so_sel   = (perm_new == PERM_SO);
            end else if (q.wr_fault) begin
                d.rsp_ack  = 1'b0;
            end else if (wr_ok) begin
                cfg_we     = 1'b1;
                d.ptr      = q.ptr + 1'b1;
                d.rsp_ack  = 1'b1;
                d.began    = 1'b0;
            end else begin
                d.rsp_ack  = 1'b0;
                d.wr_fault = 1'b1;
                d.err      = q.began ? ERR_WR_BAD : ERR_WR_OVR;
            end
        end else if (ev_rd) begin
            d.rsp_valid = 1'b1;
            d.rsp_ack   = 1'b1;
            if (q.rd_fault) begin
                d.rsp_data = '0;
            end else if (rd_ok) begin
                d.rsp_data = rd_mux;
                d.ptr      = q.ptr + 1'b1;
                if (q.ptr == ADR_ERR)
                    d.err = '0;
                if (q.ptr == ADR_IOC)
                    d.ioc_clr = 1'b1;
            end else begin
                d.rsp_data = '0;
                d.rd_fault = 1'b1;
                d.err      = ERR_RD_OVR;
            end
        end else if (ev_stop) begin
            resample   = q.so_sel;
            d.so_sel   = 1'b0;
            d.want_ptr = 1'b0;
            d.wr_fault = 1'b0;
            d.rd_fault = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign rsp_valid   = q.rsp_valid;
    assign rsp_ack     = q.rsp_ack;
    assign rsp_data    = q.rsp_data;
    assign ioc_clr_o   = q.ioc_clr;
    assign dir_o       = cfg[0];
    assign lat_o       = cfg[1];
    assign rise_en_o   = cfg[2];
    assign fall_en_o   = cfg[3];
    assign pullup_o    = cfg[4];
    assign thresh_o    = cfg[5];
    assign opendrain_o = cfg[6];
    assign slew_o      = cfg[7];

    // R1
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_wr, ev_rd, ev_stop}));

    // R1
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start || ev_wr || ev_rd) |=> rsp_valid);

    // R1
    resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_start || ev_wr || ev_rd) |=> !rsp_valid);

    // R4
    wr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && !q.want_ptr && !wr_ok) |=> (!rsp_ack && $stable(ptr_q)));

    // R5
    bad_rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && start_rd && !rd_ok) |=> (!rsp_ack && q.err == ERR_RD_BAD));

    // R7
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd && q.rd_fault) |=> (rsp_data == '0 && $stable(ptr_q)));
endmodule

// File: tb/regfront_top_tb.sv
module regfront_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 0, start_rd = 0, ev_wr = 0, ev_rd = 0, ev_stop = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] addr_pins_i = 3'b101;
    logic [7:0] pin_state_i = 8'hC3;
    logic [7:0] ioc_flags_i = 8'h5A;
    logic       rsp_valid, rsp_ack, ioc_clr_o;
    logic [7:0] rsp_data;
    logic [6:0] dev_addr_o;
    logic [7:0] dir_o, lat_o, rise_en_o, fall_en_o, pullup_o, thresh_o, opendrain_o, slew_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    typedef struct {
        logic  ack;
        logic  chk_data;
        logic  [7:0] data;
        logic  clr;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    regfront_top u_dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .start_rd(start_rd),
        .ev_wr(ev_wr), .wr_data(wr_data), .ev_rd(ev_rd), .ev_stop(ev_stop),
        .addr_pins_i(addr_pins_i), .pin_state_i(pin_state_i), .ioc_flags_i(ioc_flags_i),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data), .ioc_clr_o(ioc_clr_o),
        .dev_addr_o(dev_addr_o), .dir_o(dir_o), .lat_o(lat_o), .rise_en_o(rise_en_o),
        .fall_en_o(fall_en_o), .pullup_o(pullup_o), .thresh_o(thresh_o),
        .opendrain_o(opendrain_o), .slew_o(slew_o)
    );

    // monitor: pops one expected item per response cycle
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected response got ack=%0b exp none", rsp_ack);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_ack !== e.ack || (e.chk_data && rsp_data !== e.data) || ioc_clr_o !== e.clr) begin
                    n_fail++;
                    $display("FAIL %s got ack=%0b data=%h clr=%0b exp ack=%0b data=%h clr=%0b",
                             e.tag, rsp_ack, rsp_data, ioc_clr_o, e.ack, e.data, e.clr);
                end
            end
        end
    end

    task automatic push(input logic ack, input logic cd, input logic [7:0] dat,
                        input logic clr, input string tag);
        exp_t e;
        e.ack = ack; e.chk_data = cd; e.data = dat; e.clr = clr; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic t_start(input logic rd, input logic exp_ack, input string tag);
        @(negedge clk);
        ev_start = 1; start_rd = rd;
        push(exp_ack, 0, 8'h00, 0, tag);
        @(negedge clk);
        ev_start = 0; start_rd = 0;
    endtask

    task automatic t_wr(input logic [7:0] b, input logic exp_ack, input string tag);
        @(negedge clk);
        ev_wr = 1; wr_data = b;
        push(exp_ack, 0, 8'h00, 0, tag);
        @(negedge clk);
        ev_wr = 0;
    endtask

    task automatic t_rd(input logic [7:0] exp, input logic clr, input string tag);
        @(negedge clk);
        ev_rd = 1;
        push(1'b1, 1'b1, exp, clr, tag);
        @(negedge clk);
        ev_rd = 0;
    endtask

    task automatic t_stop();
        @(negedge clk);
        ev_stop = 1;
        @(negedge clk);
        ev_stop = 0;
    endtask

    task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic read_err(input logic [7:0] exp, input string tag);
        t_start(0, 1, "R1 write start");
        t_wr(8'h00, 1, "R2 pointer byte");
        t_start(1, 1, "R6 read start");
        t_rd(exp, 0, tag);
        t_stop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset values, R9 boot sampling
        check8(dir_o, 8'hFF, "R10 dir");
        check8(lat_o, 8'h00, "R10 lat");
        check8(pullup_o, 8'hFF, "R10 pullup");
        check8(slew_o, 8'hFF, "R10 slew");
        check8(thresh_o, 8'h00, "R10 thresh");
        check8({1'b0, dev_addr_o}, 8'h65, "R9 boot address");

        // R10 pointer starts at 0; R6 sequential live reads
        t_start(1, 1, "R1 read start at reset pointer");
        t_rd(8'h00, 0, "R10 error reg at reset");
        t_rd(8'h5A, 1, "R6 change flags with clear pulse");
        t_rd(8'hC3, 0, "R6 pin levels");
        t_rd(8'hFF, 0, "R6 direction default");
        t_stop();

        // R3 writes in both read/write blocks
        t_start(0, 1, "R1 write start");
        t_wr(8'h03, 1, "R2 pointer byte");
        t_wr(8'h12, 1, "R3 write dir");
        t_wr(8'h34, 1, "R3 write lat");
        t_stop();
        check8(dir_o, 8'h12, "R3 dir value");
        check8(lat_o, 8'h34, "R3 lat value");
        t_start(0, 1, "R1 write start");
        t_wr(8'h08, 1, "R2 pointer byte");
        t_wr(8'h3C, 1, "R3 write pullup");
        t_wr(8'h5D, 1, "R3 write thresh");
        t_stop();
        check8(pullup_o, 8'h3C, "R3 pullup value");
        check8(thresh_o, 8'h5D, "R3 thresh value");

        // R4 overrun from 0x06 onto 0x07
        t_start(0, 1, "R1 write start");
        t_wr(8'h05, 1, "R2 pointer byte");
        t_wr(8'hAA, 1, "R3 write rise");
        t_wr(8'hBB, 1, "R3 write fall");
        t_wr(8'hCC, 0, "R4 overrun refused");
        t_wr(8'hDD, 0, "R4 rest refused");
        t_stop();
        check8(rise_en_o, 8'hAA, "R3 rise value");
        check8(fall_en_o, 8'hBB, "R3 fall value");
        check8(lat_o, 8'h34, "R4 no stray write");
        read_err(8'h02, "R4 overrun code");
        read_err(8'h00, "R8 cleared on read");

        // R4 write beginning on read-only address
        t_start(0, 1, "R1 write start");
        t_wr(8'h02, 1, "R2 pointer to RO");
        t_wr(8'h77, 0, "R4 RO write refused");
        t_stop();
        // R7 read crossing 0x0B onto 0x0C; also R8 overwrite of code 0x04
        t_start(0, 1, "R1 write start");
        t_wr(8'h0A, 1, "R2 pointer byte");
        t_start(1, 1, "R6 read start");
        t_rd(8'h00, 0, "R6 opendrain default");
        t_rd(8'hFF, 0, "R6 slew default");
        t_rd(8'h00, 0, "R7 zero at unreadable");
        t_rd(8'h00, 0, "R7 zero continues");
        t_stop();
        read_err(8'h01, "R8 newest code 0x01 replaces 0x04");

        // R5 read start on invalid pointer
        t_start(0, 1, "R1 write start");
        t_wr(8'h07, 1, "R2 pointer to invalid");
        t_stop();
        t_start(1, 0, "R5 read start refused");
        t_rd(8'h00, 0, "R5 zero data");
        t_stop();
        read_err(8'h03, "R5 code 0x03");

        // R9 select-only resample
        addr_pins_i = 3'b010;
        t_start(0, 1, "R1 write start");
        t_wr(8'hB0, 1, "R2 select 0xB0");
        t_stop();
        check8({1'b0, dev_addr_o}, 8'h62, "R9 resampled address");
        addr_pins_i = 3'b111;
        t_start(0, 1, "R1 write start");
        t_wr(8'h04, 1, "R2 pointer byte");
        t_stop();
        check8({1'b0, dev_addr_o}, 8'h62, "R9 plain stop keeps address");
        t_start(0, 1, "R1 write start");
        t_wr(8'hB0, 1, "R2 select 0xB0");
        t_wr(8'h11, 0, "R9 data to 0xB0 refused");
        t_stop();
        check8({1'b0, dev_addr_o}, 8'h62, "R9 no resample after data");
        read_err(8'h04, "R9 code 0x04 for select-only write");

        repeat (3) @(negedge clk);
        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1 missing responses got %0d left exp 0", sb.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule